// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital control core of a 10-bit successive-approximation converter. Software reaches it through a small byte-wide write port and reads its state from dedicated outputs. Once the converter is enabled, a start request sets a busy bit. The sequencer then runs one bit-trial per conversion-clock enable, starting at the most significant bit. For each trial it drives a trial code to the external DAC and reads a single comparator bit. When all trials are done it publishes the result as a 16-bit high/low byte pair, in either of two justifications.

The sequencer also handles the converter's exceptional paths. A software abort keeps the old result and enforces a guard interval before acquisition resumes. A reset ends any conversion. A sleep request is handled according to which conversion clock is selected. An external periodic trigger can start a conversion and clear an attached timer.

Top module: `adc_sar_seq`

## Requirements
- R1: The stored 10-bit result appears on `{res_hi,res_lo}`. With format bit 0 it sits in bits 15..6 and bits 5..0 are zero. With format bit 1 it sits in bits 9..0 and bits 15..10 are zero.
- R2: A write to address 0 sets enable from bit 0, start/busy from bit 1 and format from bit 2. Busy is set by a start only when enable was already 1 before that write.
- R3: On completion, busy clears, the done flag sets and the result pair loads, all on the same clock edge.
- R4: Writing address 0 with bit 0 = 1 and bit 1 = 0 during a conversion aborts it. Busy clears and the result keeps its previous value.
- R5: After an abort, `acq_o` stays low for 2 conversion-clock enables and then goes high.
- R6: Reset clears enable, busy, format, interrupt enable, done flag, result and the internal sequencer state.
- R7: With `dedicated_clk` = 1, a started conversion waits for one `instr_tick` before its first trial, and the trial code reads 0 while it waits. Otherwise the first trial code, 0x200, appears on the clock after busy sets.
- R8: With `dedicated_clk` = 1, a conversion runs to completion during `sleep_req`. If the interrupt enable (bit 1 of address 1) is 1, `wake_o` rises. If it is 0, the converter powers down: `acq_o` goes low and enable stays 1.
- R9: With `dedicated_clk` = 0, `sleep_req` aborts a running conversion and powers the converter down. Enable stays 1 and the result is not updated.
- R10: A high `trig_in` while enabled sets busy. On the same edge, `timer_rst_o` pulses for one cycle.
- R11: The done flag (bit 0 of address 1) is sticky and is cleared only by a write of 0. A completion in the same cycle as that write leaves the flag at 1.
- R12: Trials run from bit 9 down to bit 0, one per `conv_tick`. A trial keeps its bit when `cmp_in` is high. Completion occurs on the `conv_tick` after the bit-0 trial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 flag/interrupt) |
| wr_data | input | 8 | Write data |
| conv_tick | input | 1 | Conversion-clock enable |
| instr_tick | input | 1 | Instruction-cycle enable |
| dedicated_clk | input | 1 | Dedicated internal conversion clock selected |
| sleep_req | input | 1 | Sleep request |
| trig_in | input | 1 | External periodic trigger |
| cmp_in | input | 1 | Comparator result for the current trial |
| en_o | output | 1 | Enable bit |
| busy_o | output | 1 | Start/busy bit |
| fmt_o | output | 1 | Format bit |
| ie_o | output | 1 | Interrupt enable bit |
| flag_o | output | 1 | Done interrupt flag |
| res_hi | output | 8 | Result high byte |
| res_lo | output | 8 | Result low byte |
| trial_code | output | 10 | Code driven to the DAC |
| acq_o | output | 1 | Input acquisition active |
| wake_o | output | 1 | Wake request |
| timer_rst_o | output | 1 | One-cycle reset pulse to the attached timer |

## Verification
Some properties are checked on every cycle: the zero padding of the justified result, that busy rises only from an enabled state, that a result change coincides with busy falling and the flag being set, that a timer pulse has a trigger behind it, and that the flag and the enable bit fall only after matching software writes. Other behaviours depend on a chain of events, and only the bench scenarios can show them. These are the guard interval after an abort, the one-tick hold under the dedicated clock, the sleep outcomes under each clock choice, the flag priority in a collision, and a result that equals the comparator's analog target.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HOLD,
      ST_TRIAL,
      ST_LAST,
      ST_GUARD
   } seq_st_t;

   localparam int ADDR_CTRL = 0;
   localparam int ADDR_FLAG = 1;

   localparam int BIT_EN   = 0;
   localparam int BIT_GO   = 1;
   localparam int BIT_FMT  = 2;
   localparam int BIT_FLAG = 0;
   localparam int BIT_IE   = 1;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
   import adc_seq_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              hw_done,
   output logic              ctrl_wr,
   output logic              flag_wr,
   output logic              en_q,
   output logic              fmt_q,
   output logic              ie_q,
   output logic              flag_q
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(ADDR_FLAG);

   logic unused_hi;
   assign unused_hi = ^wr_data[BYTE_W-1:BIT_FMT+1];

   assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
   assign flag_wr = wr_en && (wr_addr == A_FLAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         fmt_q  <= 1'b0;
         ie_q   <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            en_q  <= wr_data[BIT_EN];
            fmt_q <= wr_data[BIT_FMT];
         end
         if (flag_wr) begin
            ie_q <= wr_data[BIT_IE];
         end
         if (hw_done) begin
            flag_q <= 1'b1;
         end else if (flag_wr) begin
            flag_q <= wr_data[BIT_FLAG];
         end
      end
   end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int RES_W       = 10,
   parameter int GUARD_TICKS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr,
   input  logic             en_wd,
   input  logic             go_wd,
   input  logic             en_q,
   input  logic             ie_q,
   input  logic             dedicated_clk,
   input  logic             conv_tick,
   input  logic             instr_tick,
   input  logic             sleep_req,
   input  logic             trig_in,
   input  logic             cmp_in,
   output logic             busy_q,
   output logic             done_now,
   output logic [RES_W-1:0] res_q,
   output logic [RES_W-1:0] trial_code,
   output logic             acq_o,
   output logic             timer_rst_q
);

   localparam int IDX_W  = $clog2(RES_W);
   localparam int GCNT_W = $clog2(GUARD_TICKS + 1);
   localparam logic [IDX_W-1:0]  TOP_IDX = IDX_W'(RES_W - 1);
   localparam logic [GCNT_W-1:0] G_LAST  = GCNT_W'(GUARD_TICKS - 1);

   seq_st_t            st_q, st_d;
   logic [IDX_W-1:0]   idx_q, idx_d;
   logic [GCNT_W-1:0]  g_q, g_d;
   logic [RES_W-1:0]   acc_q, acc_d, res_d;
   logic               busy_d, pd_q, pd_d;
   logic               running, start_req, sw_off, sleep_kill, sw_abort;

   assign running    = (st_q == ST_HOLD) || (st_q == ST_TRIAL) || (st_q == ST_LAST);
   assign start_req  = en_q && ((ctrl_wr && go_wd) || trig_in);
   assign sw_off     = (ctrl_wr && !en_wd) || !en_q;
   assign sleep_kill = sleep_req && !dedicated_clk && running;
   assign sw_abort   = ctrl_wr && !go_wd && running;

   always_comb begin
      st_d     = st_q;
      idx_d    = idx_q;
      g_d      = g_q;
      acc_d    = acc_q;
      res_d    = res_q;
      busy_d   = busy_q;
      done_now = 1'b0;
      if (sw_off) begin
         st_d   = ST_IDLE;
         busy_d = 1'b0;
      end else if (sleep_kill) begin
         st_d   = ST_IDLE;
         busy_d = 1'b0;
      end else if (sw_abort) begin
         st_d   = ST_GUARD;
         g_d    = '0;
         busy_d = 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (busy_q && !pd_q) begin
                  st_d  = dedicated_clk ? ST_HOLD : ST_TRIAL;
                  idx_d = TOP_IDX;
                  acc_d = '0;
               end else if (start_req) begin
                  busy_d = 1'b1;
               end
            end
            ST_HOLD: begin
               if (instr_tick) st_d = ST_TRIAL;
            end
            ST_TRIAL: begin
               if (conv_tick) begin
                  acc_d[idx_q] = cmp_in;
                  if (idx_q == '0) st_d = ST_LAST;
                  else             idx_d = idx_q - 1'b1;
               end
            end
            ST_LAST: begin
               if (conv_tick) begin
                  res_d    = acc_q;
                  busy_d   = 1'b0;
                  done_now = 1'b1;
                  st_d     = ST_IDLE;
               end
            end
            ST_GUARD: begin
               if (start_req) busy_d = 1'b1;
               if (conv_tick) begin
                  if (g_q == G_LAST) st_d = ST_IDLE;
                  else               g_d = g_q + 1'b1;
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_comb begin
      if (!sleep_req)              pd_d = 1'b0;
      else if (!dedicated_clk)     pd_d = 1'b1;
      else if (done_now && !ie_q)  pd_d = 1'b1;
      else                         pd_d = pd_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         idx_q       <= '0;
         g_q         <= '0;
         acc_q       <= '0;
         res_q       <= '0;
         busy_q      <= 1'b0;
         pd_q        <= 1'b0;
         timer_rst_q <= 1'b0;
      end else begin
         st_q        <= st_d;
         idx_q       <= idx_d;
         g_q         <= g_d;
         acc_q       <= acc_d;
         res_q       <= res_d;
         busy_q      <= busy_d;
         pd_q        <= pd_d;
         timer_rst_q <= trig_in && en_q;
      end
   end

   logic [RES_W-1:0] probe;
   assign probe      = RES_W'(1) << idx_q;
   assign trial_code = (st_q == ST_TRIAL) ? (acc_q | probe) : acc_q;
   assign acq_o      = en_q && !pd_q && (st_q == ST_IDLE);

endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt #(
   parameter int RES_W  = 10,
   parameter int WORD_W = 16
) (
   input  logic [RES_W-1:0]  res,
   input  logic              right_just,
   output logic [WORD_W-1:0] word
);

   localparam int PAD = WORD_W - RES_W;

   logic [WORD_W-1:0] right_w, left_w;

   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      if (i < RES_W) begin : g_r
         assign right_w[i] = res[i];
      end else begin : g_rz
         assign right_w[i] = 1'b0;
      end
      if (i >= PAD) begin : g_l
         assign left_w[i] = res[i-PAD];
      end else begin : g_lz
         assign left_w[i] = 1'b0;
      end
   end

   assign word = right_just ? right_w : left_w;

endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
   import adc_seq_pkg::*;
#(
   parameter int RES_W       = 10,
   parameter int BYTE_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int GUARD_TICKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              conv_tick,
   input  logic              instr_tick,
   input  logic              dedicated_clk,
   input  logic              sleep_req,
   input  logic              trig_in,
   input  logic              cmp_in,
   output logic              en_o,
   output logic              busy_o,
   output logic              fmt_o,
   output logic              ie_o,
   output logic              flag_o,
   output logic [BYTE_W-1:0] res_hi,
   output logic [BYTE_W-1:0] res_lo,
   output logic [RES_W-1:0]  trial_code,
   output logic              acq_o,
   output logic              wake_o,
   output logic              timer_rst_o
);

   localparam int WORD_W = 2 * BYTE_W;

   if (RES_W > WORD_W || RES_W < 2) begin : g_bad_res
      $error("RES_W must lie between 2 and twice BYTE_W");
   end
   if (BYTE_W < 3) begin : g_bad_byte
      $error("BYTE_W must hold the control bits");
   end
   if (GUARD_TICKS < 1) begin : g_bad_guard
      $error("GUARD_TICKS must be at least 1");
   end

   logic              ctrl_wr, flag_wr, done_now;
   logic [RES_W-1:0]  res_q;
   logic [WORD_W-1:0] word;

   adc_seq_regs #(
      .BYTE_W (BYTE_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .hw_done (done_now),
      .ctrl_wr (ctrl_wr),
      .flag_wr (flag_wr),
      .en_q    (en_o),
      .fmt_q   (fmt_o),
      .ie_q    (ie_o),
      .flag_q  (flag_o)
   );

   adc_seq_fsm #(
      .RES_W       (RES_W),
      .GUARD_TICKS (GUARD_TICKS)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .ctrl_wr       (ctrl_wr),
      .en_wd         (wr_data[BIT_EN]),
      .go_wd         (wr_data[BIT_GO]),
      .en_q          (en_o),
      .ie_q          (ie_o),
      .dedicated_clk (dedicated_clk),
      .conv_tick     (conv_tick),
      .instr_tick    (instr_tick),
      .sleep_req     (sleep_req),
      .trig_in       (trig_in),
      .cmp_in        (cmp_in),
      .busy_q        (busy_o),
      .done_now      (done_now),
      .res_q         (res_q),
      .trial_code    (trial_code),
      .acq_o         (acq_o),
      .timer_rst_q   (timer_rst_o)
   );

   adc_seq_fmt #(
      .RES_W  (RES_W),
      .WORD_W (WORD_W)
   ) u_fmt (
      .res        (res_q),
      .right_just (fmt_o),
      .word       (word)
   );

   logic unused_flag_wr;
   assign unused_flag_wr = flag_wr;

   assign res_hi = word[WORD_W-1:BYTE_W];
   assign res_lo = word[BYTE_W-1:0];
   assign wake_o = flag_o && ie_o && sleep_req;

endmodule

// File: rtl/adc_sar_seq_chk.sv
module adc_sar_seq_chk #(
   parameter int RES_W  = 10,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [BYTE_W-1:0] wr_data,
   input logic              trig_in,
   input logic              en_o,
   input logic              busy_o,
   input logic              fmt_o,
   input logic              flag_o,
   input logic [BYTE_W-1:0] res_hi,
   input logic [BYTE_W-1:0] res_lo,
   input logic              timer_rst_o
);

   localparam int WORD_W = 2 * BYTE_W;
   localparam int PAD    = WORD_W - RES_W;

   logic [WORD_W-1:0] word;
   assign word = {res_hi, res_lo};

   assert_right_pad_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_o |-> (word[WORD_W-1:RES_W] == '0));

   assert_left_pad_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !fmt_o |-> (word[PAD-1:0] == '0));

   assert_start_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(en_o));

   assert_result_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(word) && $stable(fmt_o)) |-> ($fell(busy_o) && flag_o));

   assert_timer_pulse_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      timer_rst_o |-> $past(trig_in));

   assert_flag_sw_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> $past(wr_en && (wr_addr == ADDR_W'(1)) && !wr_data[0]));

   assert_enable_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_o) |-> $past(wr_en && (wr_addr == ADDR_W'(0)) && !wr_data[0]));

endmodule

bind adc_sar_seq adc_sar_seq_chk #(
   .RES_W  (RES_W),
   .BYTE_W (BYTE_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .trig_in     (trig_in),
   .en_o        (en_o),
   .busy_o      (busy_o),
   .fmt_o       (fmt_o),
   .flag_o      (flag_o),
   .res_hi      (res_hi),
   .res_lo      (res_lo),
   .timer_rst_o (timer_rst_o)
);

// File: tb/adc_sar_seq_bench.sv
module adc_sar_seq_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       conv_tick = 1'b0, instr_tick = 1'b0;
   logic       dedicated_clk = 1'b0, sleep_req = 1'b0, trig_in = 1'b0;
   logic       cmp_in;
   logic       en_o, busy_o, fmt_o, ie_o, flag_o, acq_o, wake_o, timer_rst_o;
   logic [7:0] res_hi, res_lo;
   logic [9:0] trial_code;

   int n_chk = 0, n_fail = 0, cyc_n = 0, wd = 0;
   int target = 0;
   bit cur_fmt = 1'b1;

   always #2 clk = ~clk;

   assign cmp_in = (int'(trial_code) <= target);

   adc_sar_seq u_adc_sar_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .conv_tick(conv_tick), .instr_tick(instr_tick), .dedicated_clk(dedicated_clk),
      .sleep_req(sleep_req), .trig_in(trig_in), .cmp_in(cmp_in),
      .en_o(en_o), .busy_o(busy_o), .fmt_o(fmt_o), .ie_o(ie_o), .flag_o(flag_o),
      .res_hi(res_hi), .res_lo(res_lo), .trial_code(trial_code), .acq_o(acq_o),
      .wake_o(wake_o), .timer_rst_o(timer_rst_o)
   );

   // behavioural reference: phase 0 idle, 1 hold, 2 converting, 3 guard
   int m_en = 0, m_busy = 0, m_fmt = 0, m_ie = 0, m_flag = 0, m_pd = 0, m_tr = 0;
   int m_res = 0, m_ph = 0, m_cnt = 0, m_g = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_busy = 0; m_fmt = 0; m_ie = 0; m_flag = 0; m_pd = 0; m_tr = 0;
         m_res = 0; m_ph = 0; m_cnt = 0; m_g = 0;
      end else begin
         automatic bit cw = wr_en && wr_addr == 2'd0;
         automatic bit fw = wr_en && wr_addr == 2'd1;
         automatic bit act = (m_ph == 1) || (m_ph == 2);
         automatic bit sreq = m_en != 0 && ((cw && wr_data[1]) || trig_in);
         automatic bit fin = 1'b0;
         automatic int n_en = cw ? int'(wr_data[0]) : m_en;
         automatic int n_fmt = cw ? int'(wr_data[2]) : m_fmt;
         automatic int n_ie = fw ? int'(wr_data[1]) : m_ie;
         automatic int n_pd;
         m_tr = (trig_in && m_en != 0) ? 1 : 0;
         if ((cw && !wr_data[0]) || m_en == 0) begin
            m_ph = 0; m_busy = 0;
         end else if (sleep_req && !dedicated_clk && act) begin
            m_ph = 0; m_busy = 0;
         end else if (cw && !wr_data[1] && act) begin
            m_ph = 3; m_g = 0; m_busy = 0;
         end else if (m_ph == 0) begin
            if (m_busy != 0 && m_pd == 0) begin
               m_ph = dedicated_clk ? 1 : 2; m_cnt = 0;
            end else if (sreq) m_busy = 1;
         end else if (m_ph == 1) begin
            if (instr_tick) begin m_ph = 2; m_cnt = 0; end
         end else if (m_ph == 2) begin
            if (conv_tick) begin
               m_cnt++;
               if (m_cnt == 11) begin
                  fin = 1'b1; m_res = target; m_busy = 0; m_ph = 0;
               end
            end
         end else begin
            if (sreq) m_busy = 1;
            if (conv_tick) begin
               m_g++;
               if (m_g == 2) m_ph = 0;
            end
         end
         if (!sleep_req) n_pd = 0;
         else if (!dedicated_clk) n_pd = 1;
         else if (fin && m_ie == 0) n_pd = 1;
         else n_pd = m_pd;
         if (fin) m_flag = 1;
         else if (fw) m_flag = wr_data[0];
         m_pd = n_pd; m_en = n_en; m_fmt = n_fmt; m_ie = n_ie;
      end
   end

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic int exp_word();
      return (m_fmt != 0) ? m_res : ((m_res << 6) & 16'hFFFF);
   endfunction

   // cycle comparison against the reference model
   always @(negedge clk) begin
      chk("R1", "result word", {16'h0, res_hi, res_lo}, exp_word());
      chk("R2", "enable", en_o, m_en);
      chk("R3", "busy", busy_o, m_busy);
      chk("R11", "done flag", flag_o, m_flag);
      chk("R5", "acquire", acq_o, (m_en != 0 && m_pd == 0 && m_ph == 0));
      chk("R10", "timer pulse", timer_rst_o, m_tr);
      chk("R8", "wake", wake_o, (m_flag != 0 && m_ie != 0 && sleep_req));
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 100000) begin
         n_fail++;
         $display("FAIL R3 watchdog: actual hung expected finished");
         summary();
      end
   end

   task automatic cyc();
      @(negedge clk);
      #1;
      cyc_n++;
      conv_tick  = (cyc_n % 3 == 0);
      instr_tick = (cyc_n % 5 == 0);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic start(input int t);
      target = t;
      wr(2'd0, {5'b0, cur_fmt, 2'b11});
   endtask

   task automatic wait_done();
      for (int i = 0; i < 300 && busy_o; i++) cyc();
   endtask

   function automatic int word_now();
      return {res_hi, res_lo};
   endfunction

   initial begin
      int prev;
      repeat (3) cyc();
      chk("R6", "reset enable", en_o, 0);
      chk("R6", "reset busy", busy_o, 0);
      chk("R6", "reset result", word_now(), 0);
      chk("R6", "reset flag", flag_o, 0);
      rst_n = 1'b1;
      cyc();

      // R2: start while disabled is ignored
      wr(2'd0, 8'h02);
      cyc(); cyc();
      chk("R2", "start while off", busy_o, 0);

      // R12 / R1 right justified
      wr(2'd0, 8'h05);
      start(10'h2A5);
      chk("R2", "busy after start", busy_o, 1);
      cyc();
      chk("R12", "first trial code", trial_code, 10'h200);
      wait_done();
      chk("R12", "result value", word_now(), 16'h02A5);
      chk("R3", "flag on completion", flag_o, 1);

      // R1 left justified
      cur_fmt = 1'b0;
      wr(2'd0, 8'h01);
      chk("R1", "left layout", word_now(), 16'hA940);

      start(0);     wait_done(); cyc();
      chk("R12", "zero input", word_now(), 16'h0000);
      start(10'h3FF); wait_done(); cyc();
      chk("R12", "full scale", word_now(), 16'hFFC0);

      // R11 clear, then collision
      wr(2'd1, 8'h00);
      chk("R11", "sw clear", flag_o, 0);
      start(10'h155);
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h00;
      for (int i = 0; i < 300 && busy_o; i++) cyc();
      wr_en = 1'b0;
      chk("R11", "hw set wins", flag_o, 1);

      // R4 / R5 abort
      cur_fmt = 1'b1;
      wr(2'd0, 8'h05);
      prev = word_now();
      start(10'h0F0);
      repeat (6) cyc();
      wr(2'd0, 8'h05);
      chk("R4", "busy after abort", busy_o, 0);
      chk("R4", "result kept", word_now(), prev);
      chk("R5", "guard acquire low", acq_o, 0);
      repeat (8) cyc();
      chk("R5", "acquire resumed", acq_o, 1);

      // R10 trigger
      target = 10'h1C3;
      trig_in = 1'b1; cyc(); trig_in = 1'b0;
      chk("R10", "trigger busy", busy_o, 1);
      chk("R10", "timer pulse", timer_rst_o, 1);
      cyc();
      chk("R10", "timer single", timer_rst_o, 0);
      wait_done();
      chk("R10", "trigger result", word_now(), 10'h1C3);

      // R7 dedicated clock hold
      dedicated_clk = 1'b1;
      start(10'h321);
      cyc();
      chk("R7", "hold code", trial_code, 0);
      wait_done();
      chk("R7", "hold result", word_now(), 10'h321);

      // R8 sleep with interrupt enabled
      wr(2'd1, 8'h02);
      start(10'h0AB);
      sleep_req = 1'b1;
      wait_done();
      chk("R8", "sleep result", word_now(), 10'h0AB);
      chk("R8", "wake", wake_o, 1);
      sleep_req = 1'b0; cyc();

      // R8 sleep with interrupt disabled
      wr(2'd1, 8'h00);
      start(10'h2F0);
      sleep_req = 1'b1;
      wait_done();
      cyc();
      chk("R8", "powered down", acq_o, 0);
      chk("R8", "enable kept", en_o, 1);
      chk("R8", "no wake", wake_o, 0);
      sleep_req = 1'b0; cyc(); cyc();
      chk("R8", "power back", acq_o, 1);

      // R9 sleep with other clock
      dedicated_clk = 1'b0;
      prev = word_now();
      start(10'h111);
      repeat (5) cyc();
      sleep_req = 1'b1; cyc();
      chk("R9", "sleep abort busy", busy_o, 0);
      chk("R9", "enable kept", en_o, 1);
      chk("R9", "result kept", word_now(), prev);
      chk("R9", "converter off", acq_o, 0);
      sleep_req = 1'b0; cyc();

      // R6 reset mid conversion
      start(10'h099);
      repeat (5) cyc();
      rst_n = 1'b0; cyc();
      chk("R6", "reset busy", busy_o, 0);
      chk("R6", "reset enable", en_o, 0);
      chk("R6", "reset result", word_now(), 0);
      rst_n = 1'b1;
      repeat (3) cyc();
      summary();
   end

endmodule